// File: doc/BRIEF.md
# Inter-Port Hardware Semaphore Bank

This block holds a small bank of one-bit hardware semaphores that two independent ports, called left and right, use to agree on who may touch a shared resource. Each port has its own select, index, write strobe with one data bit, and read strobe. A port requests a semaphore by writing 0 to it and releases it by writing 1. Reading a semaphore returns 0 to the port that owns it and 1 to any other port. Software asks for a token, reads it back, and learns whether it won.

A request that meets a semaphore held by the other port is not lost. It stays pending and turns into a grant on the cycle the owner releases. When both ports ask for the same free semaphore in one cycle, the left port is granted and the right request becomes pending. The semaphore path is separate from any data memory path.

Top module: `sem_bank`

## Requirements
- R1: After reset every semaphore is free with no pending request, and a read of any index from either port returns 1.
- R2: A write or read acts only on the semaphore named by the index (bits [IDX_W-1:0]) and only while that port's select is 1. A strobe with select at 0 has no effect.
- R3: A write of 0 to a free semaphore grants it to the writing port on the next clock edge. After that a read returns 0 on the owning port and 1 on the other port.
- R4: A write of 1 from the owning port releases the semaphore. When no request is pending it becomes free and reads 1 on both ports.
- R5: A write of 1 from a port that does not own the semaphore is ignored.
- R6: When both ports write 0 to the same free semaphore in the same cycle, the left port is granted and the right request is held pending.
- R7: A write of 0 to a semaphore owned by the other port stays pending. It is granted to the waiting port in the same edge that applies the owner's release.
- R8: A read strobe loads rdata with the port's view of the indexed semaphore, as it stood before that edge, one cycle later. Without a read strobe rdata holds its value.
- R9: A write of 0 from the port that already owns the semaphore changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_l_i | input | 1 | Left port semaphore select |
| idx_l_i | input | IDX_W | Left port semaphore index |
| wr_l_i | input | 1 | Left port write strobe |
| wdata_l_i | input | 1 | Left write value: 0 requests, 1 releases |
| rd_l_i | input | 1 | Left port read strobe |
| rdata_l_o | output | 1 | Left read result: 0 when owned by left |
| sel_r_i | input | 1 | Right port semaphore select |
| idx_r_i | input | IDX_W | Right port semaphore index |
| wr_r_i | input | 1 | Right port write strobe |
| wdata_r_i | input | 1 | Right write value: 0 requests, 1 releases |
| rd_r_i | input | 1 | Right port read strobe |
| rdata_r_o | output | 1 | Right read result: 0 when owned by right |

## Verification
The bench builds the block with the default NUM_SEM of 8. This lets it sweep every index, including the highest one, after reset and check that each semaphore is independent. Contention and handoff run on indices in the middle of the range, so a decode fault that spills into a neighbouring semaphore shows up in the reads of the adjacent index.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;
endpackage

// File: rtl/sem_port_dec.sv
module sem_port_dec #(
  parameter int NUM_SEM = 8,
  parameter int IDX_W   = $clog2(NUM_SEM)
) (
  input  logic               sel_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic               wr_i,
  input  logic               wdata_i,
  output logic [NUM_SEM-1:0] req_o,
  output logic [NUM_SEM-1:0] rel_o
);
  logic wr_act;
  assign wr_act = sel_i & wr_i;

  for (genvar g = 0; g < NUM_SEM; g++) begin : g_dec
    logic hit;
    assign hit      = (idx_i == IDX_W'(g));
    assign req_o[g] = wr_act & hit & ~wdata_i;
    assign rel_o[g] = wr_act & hit &  wdata_i;
  end
endmodule

// File: rtl/sem_cell.sv
module sem_cell
  import sem_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   req_l_i,
  input  logic   rel_l_i,
  input  logic   req_r_i,
  input  logic   rel_r_i,
  output owner_e owner_o
);
  owner_e owner_q, owner_d;
  logic   pend_l_q, pend_r_q, pend_l_d, pend_r_d;
  logic   own_l, own_r, rel_l_ok, rel_r_ok, want_l, want_r, avail;

  assign own_l    = (owner_q == OWN_LEFT);
  assign own_r    = (owner_q == OWN_RIGHT);
  // release counts only from the owner
  assign rel_l_ok = rel_l_i & own_l;
  assign rel_r_ok = rel_r_i & own_r;
  // owner's own re-request is a no-op
  assign want_l   = pend_l_q | (req_l_i & ~own_l);
  assign want_r   = pend_r_q | (req_r_i & ~own_r);
  assign avail    = (owner_q == OWN_NONE) | rel_l_ok | rel_r_ok;

  always_comb begin
    owner_d  = owner_q;
    pend_l_d = want_l;
    pend_r_d = want_r;
    if (avail) begin
      if (want_l) begin
        owner_d  = OWN_LEFT;
        pend_l_d = 1'b0;
      end else if (want_r) begin
        owner_d  = OWN_RIGHT;
        pend_r_d = 1'b0;
      end else begin
        owner_d  = OWN_NONE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q  <= OWN_NONE;
      pend_l_q <= 1'b0;
      pend_r_q <= 1'b0;
    end else begin
      owner_q  <= owner_d;
      pend_l_q <= pend_l_d;
      pend_r_q <= pend_r_d;
    end
  end

  assign owner_o = owner_q;

  // R1
  no_orphan_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_NONE) |-> (!pend_l_q && !pend_r_q));
  // R3
  free_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_NONE && req_l_i) |=> (owner_q == OWN_LEFT));
  // R5
  foreign_rel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_RIGHT && rel_l_i && !rel_r_i) |=> (owner_q == OWN_RIGHT));
  // R6
  tie_left_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_NONE && req_l_i && req_r_i) |=> (owner_q == OWN_LEFT && pend_r_q));
  // R7
  handoff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_LEFT && rel_l_i && pend_r_q) |=> (owner_q == OWN_RIGHT && !pend_r_q));
endmodule

// File: rtl/sem_bank.sv
module sem_bank
  import sem_pkg::*;
#(
  parameter int NUM_SEM = 8,
  parameter int IDX_W   = $clog2(NUM_SEM)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_l_i,
  input  logic [IDX_W-1:0] idx_l_i,
  input  logic             wr_l_i,
  input  logic             wdata_l_i,
  input  logic             rd_l_i,
  output logic             rdata_l_o,
  input  logic             sel_r_i,
  input  logic [IDX_W-1:0] idx_r_i,
  input  logic             wr_r_i,
  input  logic             wdata_r_i,
  input  logic             rd_r_i,
  output logic             rdata_r_o
);
  logic [NUM_SEM-1:0] req_l, rel_l, req_r, rel_r;
  owner_e             owner [NUM_SEM];
  logic               view_l, view_r, rdata_l_q, rdata_r_q;

  sem_port_dec #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W)) u_dec_l (
    .sel_i(sel_l_i), .idx_i(idx_l_i), .wr_i(wr_l_i), .wdata_i(wdata_l_i),
    .req_o(req_l), .rel_o(rel_l)
  );
  sem_port_dec #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W)) u_dec_r (
    .sel_i(sel_r_i), .idx_i(idx_r_i), .wr_i(wr_r_i), .wdata_i(wdata_r_i),
    .req_o(req_r), .rel_o(rel_r)
  );

  for (genvar g = 0; g < NUM_SEM; g++) begin : g_cell
    sem_cell u_cell (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .req_l_i(req_l[g]), .rel_l_i(rel_l[g]),
      .req_r_i(req_r[g]), .rel_r_i(rel_r[g]),
      .owner_o(owner[g])
    );
  end

  // 0 = owned by the reading port
  assign view_l = (owner[idx_l_i] != OWN_LEFT);
  assign view_r = (owner[idx_r_i] != OWN_RIGHT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_l_q <= 1'b1;
      rdata_r_q <= 1'b1;
    end else begin
      if (sel_l_i && rd_l_i) rdata_l_q <= view_l;
      if (sel_r_i && rd_r_i) rdata_r_q <= view_r;
    end
  end

  assign rdata_l_o = rdata_l_q;
  assign rdata_r_o = rdata_r_q;

  // R8
  rd_hold_l_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_l_i && rd_l_i) |=> $stable(rdata_l_o));
  // R8
  rd_hold_r_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_r_i && rd_r_i) |=> $stable(rdata_r_o));
  // R3
  no_double_own_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_l_i && rd_l_i && sel_r_i && rd_r_i && idx_l_i == idx_r_i)
      |=> (rdata_l_o || rdata_r_o));
endmodule

// File: tb/tb_sem_bank.sv
module tb_sem_bank;
  localparam int NUM_SEM = 8;
  localparam int IDX_W   = $clog2(NUM_SEM);

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic sel_l_i = 0, wr_l_i = 0, wdata_l_i = 0, rd_l_i = 0;
  logic sel_r_i = 0, wr_r_i = 0, wdata_r_i = 0, rd_r_i = 0;
  logic [IDX_W-1:0] idx_l_i = '0, idx_r_i = '0;
  logic rdata_l_o, rdata_r_o;
  int n_chk = 0, n_bad = 0;

  always #10 clk_i = ~clk_i;

  sem_bank #(.NUM_SEM(NUM_SEM)) dut (.*);

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic idle();
    sel_l_i = 0; wr_l_i = 0; rd_l_i = 0; wdata_l_i = 0;
    sel_r_i = 0; wr_r_i = 0; rd_r_i = 0; wdata_r_i = 0;
  endtask

  // one write cycle; port 0 = left, 1 = right
  task automatic wr(int port, int idx, logic val, logic sel = 1'b1);
    @(negedge clk_i);
    if (port == 0) begin sel_l_i = sel; idx_l_i = IDX_W'(idx); wr_l_i = 1; wdata_l_i = val; end
    else           begin sel_r_i = sel; idx_r_i = IDX_W'(idx); wr_r_i = 1; wdata_r_i = val; end
    @(negedge clk_i); idle();
  endtask

  task automatic wr_both(int idx, logic vl, logic vr);
    @(negedge clk_i);
    sel_l_i = 1; idx_l_i = IDX_W'(idx); wr_l_i = 1; wdata_l_i = vl;
    sel_r_i = 1; idx_r_i = IDX_W'(idx); wr_r_i = 1; wdata_r_i = vr;
    @(negedge clk_i); idle();
  endtask

  // read both ports; results valid at the negedge after the strobe edge
  task automatic rd(int idx, string req, logic exp_l, logic exp_r);
    @(negedge clk_i);
    sel_l_i = 1; idx_l_i = IDX_W'(idx); rd_l_i = 1;
    sel_r_i = 1; idx_r_i = IDX_W'(idx); rd_r_i = 1;
    @(negedge clk_i); idle();
    chk({req, " left"},  rdata_l_o, exp_l);
    chk({req, " right"}, rdata_r_o, exp_r);
  endtask

  task automatic t_reset();
    chk("R1 rdata_l at reset", rdata_l_o, 1'b1);
    chk("R1 rdata_r at reset", rdata_r_o, 1'b1);
    for (int i = 0; i < NUM_SEM; i++) rd(i, "R1 free", 1'b1, 1'b1);
  endtask

  task automatic t_grant();
    wr(0, 3, 1'b0);
    rd(3, "R3 grant", 1'b0, 1'b1);
    rd(2, "R2 neighbour lo", 1'b1, 1'b1);
    rd(4, "R2 neighbour hi", 1'b1, 1'b1);
  endtask

  task automatic t_sel_low();
    wr(1, 5, 1'b0, 1'b0);
    rd(5, "R2 sel low", 1'b1, 1'b1);
  endtask

  task automatic t_foreign_rel();
    wr(1, 3, 1'b1);
    rd(3, "R5 foreign release", 1'b0, 1'b1);
  endtask

  task automatic t_reown_release();
    wr(0, 3, 1'b0);
    rd(3, "R9 re-request", 1'b0, 1'b1);
    wr(0, 3, 1'b1);
    rd(3, "R4 release", 1'b1, 1'b1);
  endtask

  task automatic t_contend();
    wr_both(6, 1'b0, 1'b0);
    rd(6, "R6 tie left wins", 1'b0, 1'b1);
    wr(0, 6, 1'b1);
    rd(6, "R7 tie pend handoff", 1'b1, 1'b0);
    wr(1, 6, 1'b1);
    rd(6, "R4 right release", 1'b1, 1'b1);
  endtask

  task automatic t_pending();
    wr(1, 1, 1'b0);
    wr(0, 1, 1'b0);
    rd(1, "R7 pending", 1'b1, 1'b0);
    wr(1, 1, 1'b1);
    rd(1, "R7 handoff to left", 1'b0, 1'b1);
    wr(0, 1, 1'b1);
    rd(1, "R4 after handoff", 1'b1, 1'b1);
  endtask

  task automatic t_hold();
    wr(0, 0, 1'b0);
    rd(0, "R8 load", 1'b0, 1'b1);
    wr(0, 0, 1'b1);
    @(negedge clk_i);
    chk("R8 hold left", rdata_l_o, 1'b0);
    chk("R8 hold right", rdata_r_o, 1'b1);
    rd(0, "R8 reload", 1'b1, 1'b1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        t_reset();
        t_grant();
        t_sel_low();
        t_foreign_rel();
        t_reown_release();
        t_contend();
        t_pending();
        t_hold();
      end
      begin
        repeat (20000) @(posedge clk_i);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule